// File: doc/BRIEF.md
# Interrupt Status Aggregator with Message-Signalled Pulse

This block holds a 32-bit interrupt status word. Two hardware event sources and software can both add bits to it, and software can remove them. Two hardware sources feed it: a computation-complete event and a transfer-complete event. Each one sets its own status bit on a single-cycle pulse. Software uses a simple register write port. A write to the raise offset ORs the data into the status word. A write to the acknowledge offset clears the bits that are set in the data. A combinational read port returns the status word.

The block reports interrupts in one of two ways, chosen by the message-enable input. With message signalling on, every raise event that leaves the status nonzero produces a one-clock pulse. Downstream logic turns that pulse into a bus message. With message signalling off, the same event asserts a level-sensitive legacy line. That line drops only when an acknowledge leaves the status at zero while message signalling is off. Both outputs are registered and react in the cycle after the event.

Top module: `irq_agg`

## Requirements
- R1: After reset the status word is zero and both the legacy line and the message pulse are low.
- R2: A pulse on `calc_done_i` sets status bit 0 (value 0x00000001). A pulse on `xfer_done_i` sets status bit 8 (value 0x00000100). The new value is readable in the following cycle.
- R3: A write to offset 0x60 ORs the written data into the status word.
- R4: A write to offset 0x64 clears every status bit that is set in the written data.
- R5: Reading offset 0x24 returns the status word. Reading any other offset returns zero.
- R6: With `msi_en_i` high, every raise event (hardware pulse or write to 0x60) that leaves the status nonzero produces `msi_pulse_o` high for exactly one cycle, and the legacy line does not change.
- R7: With `msi_en_i` low, a raise event that leaves the status nonzero asserts `intx_o` in the next cycle.
- R8: `intx_o` falls only after an acknowledge that leaves the status zero while `msi_en_i` is low. It stays high while any bit remains set, and it stays high through an acknowledge made while `msi_en_i` is high.
- R9: A write of zero to 0x60 while the status is zero produces neither a pulse nor a legacy assertion.
- R10: When a hardware set pulse and an acknowledge of the same bit fall in the same cycle, the bit stays set. Other bits named by that acknowledge are still cleared.
- R11: Writes to offsets other than 0x60 and 0x64 leave the status word and both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| calc_done_i | input | 1 | Computation-complete set pulse |
| xfer_done_i | input | 1 | Transfer-complete set pulse |
| msi_en_i | input | 1 | Selects message-signalled reporting |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write offset |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 8 | Register read offset |
| rd_data_o | output | 32 | Read data, combinational |
| intx_o | output | 1 | Level-sensitive legacy interrupt |
| msi_pulse_o | output | 1 | One-cycle message-signalled interrupt request |

## Verification
A hardware set pulse and a software acknowledge can fall in the same cycle, and they can target the same status bit. The bench provokes this by holding `calc_done_i` high during the very clock in which it writes an acknowledge of bit 0 and bit 1. It then reads 0x24. The expected result is that bit 0 has survived, bit 1 has gone, and a raise has been reported. A second collision pairs an acknowledge to zero with the message-enable setting, to confirm that the legacy line keeps its level.

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int CALC_BIT  = 0,
  parameter int XFER_BIT  = 8,
  parameter logic [AW-1:0] STAT_OFS  = 8'h24,
  parameter logic [AW-1:0] RAISE_OFS = 8'h60,
  parameter logic [AW-1:0] LOWER_OFS = 8'h64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          calc_done_i,
  input  logic          xfer_done_i,
  input  logic          msi_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          intx_o,
  output logic          msi_pulse_o
);

  localparam logic [DW-1:0] CALC_MASK = DW'(1) << CALC_BIT;
  localparam logic [DW-1:0] XFER_MASK = DW'(1) << XFER_BIT;

  logic [DW-1:0] status_q, hw_set, sw_set, sw_clr, status_d;
  logic          raise_evt, lower_evt, nz_d;

  assign hw_set    = (calc_done_i ? CALC_MASK : '0) | (xfer_done_i ? XFER_MASK : '0);
  assign sw_set    = (wr_en_i && wr_addr_i == RAISE_OFS) ? wr_data_i : '0;
  assign sw_clr    = (wr_en_i && wr_addr_i == LOWER_OFS) ? wr_data_i : '0;
  assign raise_evt = calc_done_i || xfer_done_i || (wr_en_i && wr_addr_i == RAISE_OFS);
  assign lower_evt = wr_en_i && wr_addr_i == LOWER_OFS;

  // hardware set takes precedence over a same-cycle acknowledge
  assign status_d  = ((status_q & ~sw_clr) | hw_set | sw_set);
  assign nz_d      = |status_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q    <= '0;
      intx_o      <= 1'b0;
      msi_pulse_o <= 1'b0;
    end else begin
      status_q    <= status_d;
      msi_pulse_o <= raise_evt && nz_d && msi_en_i;
      if (raise_evt && nz_d && !msi_en_i)
        intx_o <= 1'b1;
      else if (lower_evt && !nz_d && !msi_en_i)
        intx_o <= 1'b0;
    end
  end

  assign rd_data_o = (rd_addr_i == STAT_OFS) ? status_q : '0;

  assert_pulse_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse_o |-> (status_q != '0));
  assert_pulse_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_pulse_o) |-> $past(msi_en_i));
  assert_intx_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intx_o) |-> (status_q != '0) && !$past(msi_en_i));
  assert_intx_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intx_o) |-> (status_q == '0) && !$past(msi_en_i));
  assert_calc_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    calc_done_i |=> status_q[CALC_BIT]);
  assert_xfer_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_i |=> status_q[XFER_BIT]);

endmodule

// File: tb/irq_agg_tb.sv
`timescale 1ns/1ps
module irq_agg_tb;
  logic        clk = 0, rst_n = 0;
  logic        calc_done_i = 0, xfer_done_i = 0, msi_en_i = 0, wr_en_i = 0;
  logic [7:0]  wr_addr_i = 0, rd_addr_i = 8'h24;
  logic [31:0] wr_data_i = 0, rd_data_o;
  logic        intx_o, msi_pulse_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_agg u_dut (.clk(clk), .rst_n(rst_n), .calc_done_i(calc_done_i),
    .xfer_done_i(xfer_done_i), .msi_en_i(msi_en_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .intx_o(intx_o), .msi_pulse_o(msi_pulse_o));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk); wr_en_i = 0;
  endtask

  task automatic rd_stat(string tag, logic [31:0] exp);
    rd_addr_i = 8'h24; #0.1; chk(tag, rd_data_o, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rd_stat("R1 status", 0);
    chk("R1 intx", intx_o, 0);
    chk("R1 msi", msi_pulse_o, 0);
  endtask

  task automatic t_hw_sources;
    @(negedge clk); calc_done_i = 1;
    @(negedge clk); calc_done_i = 0; rd_stat("R2 calc bit0", 32'h1);
    chk("R7 intx after hw", intx_o, 1);
    xfer_done_i = 1;
    @(negedge clk); xfer_done_i = 0; rd_stat("R2 xfer bit8", 32'h101);
    wr(8'h64, 32'h101);
    rd_stat("R4 clear both", 0);
    chk("R8 intx drop", intx_o, 0);
  endtask

  task automatic t_raise_lower_legacy;
    wr(8'h60, 32'h3);
    rd_stat("R3 raise", 32'h3);
    chk("R7 intx rise", intx_o, 1);
    chk("R7 no msi", msi_pulse_o, 0);
    wr(8'h60, 32'hA000_0000);
    rd_stat("R3 or accumulate", 32'hA000_0003);
    wr(8'h64, 32'h8000_0001);
    rd_stat("R4 partial clear", 32'h2000_0002);
    chk("R8 intx held nonzero", intx_o, 1);
    wr(8'h64, 32'hFFFF_FFFF);
    rd_stat("R4 full clear", 0);
    chk("R8 intx fell", intx_o, 0);
  endtask

  task automatic t_read_other;
    wr(8'h60, 32'h55);
    rd_addr_i = 8'h20; #0.1; chk("R5 other offset", rd_data_o, 0);
    rd_stat("R5 status offset", 32'h55);
    wr(8'h64, 32'h55);
  endtask

  task automatic t_msi;
    msi_en_i = 1;
    wr(8'h60, 32'h4);
    chk("R6 pulse", msi_pulse_o, 1);
    chk("R6 intx untouched", intx_o, 0);
    @(negedge clk); chk("R6 one cycle", msi_pulse_o, 0);
    wr(8'h60, 32'h0);
    chk("R6 fresh pulse zero mask nonzero status", msi_pulse_o, 1);
    @(negedge clk); calc_done_i = 1;
    @(negedge clk); calc_done_i = 0;
    chk("R6 pulse from hw", msi_pulse_o, 1);
    wr(8'h64, 32'h5);
    chk("R6 no pulse on lower", msi_pulse_o, 0);
    rd_stat("R6 cleared", 0);
    wr(8'h60, 32'h0);
    chk("R9 no pulse", msi_pulse_o, 0);
    chk("R9 no intx", intx_o, 0);
    msi_en_i = 0;
    wr(8'h60, 32'h0);
    chk("R9 no intx legacy", intx_o, 0);
  endtask

  task automatic t_intx_msi_mix;
    wr(8'h60, 32'h10);
    chk("R7 intx", intx_o, 1);
    msi_en_i = 1;
    wr(8'h64, 32'h10);
    rd_stat("R8 status zero", 0);
    chk("R8 intx kept with msi on", intx_o, 1);
    msi_en_i = 0;
    wr(8'h64, 32'h0);
    chk("R8 intx drops msi off", intx_o, 0);
  endtask

  task automatic t_collision;
    wr(8'h60, 32'h3);
    @(negedge clk); calc_done_i = 1; wr_en_i = 1; wr_addr_i = 8'h64; wr_data_i = 32'h3;
    @(negedge clk); calc_done_i = 0; wr_en_i = 0;
    rd_stat("R10 set wins", 32'h1);
    chk("R10 intx high", intx_o, 1);
    wr(8'h64, 32'h1);
    chk("R10 intx low after", intx_o, 0);
  endtask

  task automatic t_other_writes;
    wr(8'h60, 32'h8);
    wr(8'h24, 32'hFFFF_FFFF);
    rd_stat("R11 status write ignored", 32'h8);
    wr(8'h68, 32'hFFFF_FFFF);
    rd_stat("R11 unused offset ignored", 32'h8);
    chk("R11 intx unchanged", intx_o, 1);
    chk("R11 no pulse", msi_pulse_o, 0);
    wr(8'h64, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_hw_sources();
    t_raise_lower_legacy();
    t_read_other();
    t_msi();
    t_intx_msi_mix();
    t_collision();
    t_other_writes();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule